// File: doc/BRIEF.md
# Burst Address Generator with Load, Hold, Advance and Clear

This block produces the address that a memory port uses on each clock cycle. On every cycle it picks one of four sources: an address supplied from outside, the previous address plus one, the previous address unchanged, or zero. A host can therefore start a burst at any location with a single strobe and then walk through consecutive locations without presenting further addresses. It can also pause the walk, or return to location zero.

The chosen address reaches the output combinationally from the controls of the current cycle, so a load, an advance or a clear takes effect in the same access with no dead cycle. At the rising edge the address in use is kept as the base for the next cycle. The generator has no chip-select or byte-select qualification. It acts on its own controls whether or not the memory port it feeds is selected in that cycle. The address width is a parameter with a default of 16 bits. All controls are active low.

Top module: `addr_burst_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge, the kept address becomes 0. With `clr_n`, `load_n` and `adv_n` all high after that, `acc_addr` reads 0.
- R2: When `clr_n` is high and `load_n` is low, `acc_addr` equals `ext_addr` in the same cycle.
- R3: When `clr_n`, `load_n` and `adv_n` are all high, `acc_addr` equals the address used in the previous cycle.
- R4: When `clr_n` and `load_n` are high and `adv_n` is low, `acc_addr` equals the previous cycle's address plus one.
- R5: An advance from the all-ones address gives 0.
- R6: When `clr_n` is low, `acc_addr` is 0 in the same cycle, whatever `load_n`, `adv_n` and `ext_addr` are.
- R7: When `load_n` and `adv_n` are both low and `clr_n` is high, the load wins and `acc_addr` equals `ext_addr`, not an incremented value.
- R8: The address used in any cycle becomes the base for the next cycle. This holds for loads, advances and clears alike.
- R9: The counter advances on every rising edge at which `adv_n` is low. No other enable is needed, so a run of advances produces consecutive addresses that wrap through 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low; clears the kept address |
| ext_addr | input | AW | Address from outside, used on a load |
| load_n | input | 1 | Load strobe, active low |
| adv_n | input | 1 | Advance enable, active low |
| clr_n | input | 1 | Counter clear, active low; highest priority |
| acc_addr | output | AW | Address used by the current access |

## Verification
The hardest case to reach from the ports is the meeting of every control pattern with every possible base address. This matters most for the wrap from all-ones and for the clear and load overriding an advance from an arbitrary start. The bench runs a small four-bit instance. Before each trial it loads each of the sixteen start values. It then applies all eight control combinations, with every external value, in the next cycle. A further all-high cycle confirms that the result became the new base.

// File: rtl/addr_burst_gen.sv
module addr_burst_gen #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ext_addr,
  input  logic          load_n,
  input  logic          adv_n,
  input  logic          clr_n,
  output logic [AW-1:0] acc_addr
);

  logic [AW-1:0] last_q;
  logic [AW-1:0] bumped;

  assign bumped = last_q + AW'(1);

  always_comb begin
    if (!clr_n)       acc_addr = '0;
    else if (!load_n) acc_addr = ext_addr;
    else if (!adv_n)  acc_addr = bumped;
    else              acc_addr = last_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= acc_addr;
  end

endmodule

// File: rtl/addr_burst_gen_chk.sv
module addr_burst_gen_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] ext_addr,
  input logic          load_n,
  input logic          adv_n,
  input logic          clr_n,
  input logic [AW-1:0] acc_addr
);

  AST_CLEAR_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> acc_addr == '0); // R6

  AST_LOAD_TAKES_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !load_n) |-> acc_addr == ext_addr); // R2

  AST_HOLD_REPEATS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && adv_n && $past(rst_n)) |-> acc_addr == $past(acc_addr)); // R3

  AST_ADVANCE_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && !adv_n && $past(rst_n)) |-> acc_addr == AW'($past(acc_addr) + AW'(1))); // R4

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && !adv_n && $past(rst_n) && ($past(acc_addr) == {AW{1'b1}})) |-> acc_addr == '0); // R5

endmodule

bind addr_burst_gen addr_burst_gen_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_addr_burst_gen.sv
module tb_addr_burst_gen;
  localparam int AW = 4;
  localparam logic [AW-1:0] TOP = {AW{1'b1}};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic          load_n = 1'b1;
  logic          adv_n = 1'b1;
  logic          clr_n = 1'b1;
  logic [AW-1:0] acc_addr;

  int checks = 0;
  int fails = 0;
  bit ended = 1'b0;
  logic [AW-1:0] prev = '0;

  always #10 clk = ~clk;

  addr_burst_gen #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr),
    .load_n(load_n), .adv_n(adv_n), .clr_n(clr_n), .acc_addr(acc_addr)
  );

  task automatic chk(input string tag, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: acc_addr=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic step(input logic l, input logic a, input logic c,
                      input logic [AW-1:0] e, input string forced_tag);
    logic [AW-1:0] exp;
    string tag;
    @(negedge clk);
    load_n = l; adv_n = a; clr_n = c; ext_addr = e;
    #2;
    if (!c) begin exp = '0; tag = "R6"; end
    else if (!l && !a) begin exp = e; tag = "R7"; end
    else if (!l) begin exp = e; tag = "R2"; end
    else if (!a) begin exp = prev + AW'(1); tag = (prev == TOP) ? "R5" : "R4"; end
    else begin exp = prev; tag = "R3"; end
    if (forced_tag != "") tag = forced_tag;
    chk(tag, acc_addr, exp);
    prev = exp;
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: acc_addr=%0d expected=run completion", acc_addr);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R1", acc_addr, '0);
    prev = '0;

    step(0, 1, 1, 4'd9, "R2");
    step(1, 1, 1, 4'd0, "R8");
    @(negedge clk);
    rst_n = 1'b0;
    load_n = 1'b1; adv_n = 1'b1; clr_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    prev = '0;
    #2;
    chk("R1", acc_addr, '0);

    step(0, 1, 1, 4'd13, "R2");
    for (int i = 0; i < 40; i++) step(1, 0, 1, 4'd0, "R9");

    step(0, 1, 1, 4'd7, "R2");
    step(0, 0, 0, 4'd11, "R6");
    step(1, 0, 1, 4'd0, "R8");

    for (int s = 0; s < 16; s++)
      for (int c = 0; c < 8; c++)
        for (int e = 0; e < 16; e++) begin
          step(0, 1, 1, AW'(s), "R2");
          step(c[0], c[1], c[2], AW'(e), "");
          step(1, 1, 1, 4'd0, "R8");
        end

    finish_run();
  end
endmodule